// File: doc/BRIEF.md
# Sliding-Window Macro-Block Pixel Distributor

The block takes a raster pixel stream, one pixel per clock, framed by a vertical blanking flag, a horizontal blanking flag and an active-pixel qualifier. It keeps the most recent `V` lines in `V` circular line buffers. Frame line `N` goes into buffer `N mod V`. Whenever a full `H` x `V` window is available at an allowed position, the block presents it on one wide output bus together with a `valid` strobe. The first window of each frame also carries a `sof` strobe. Downstream processing engines take one window per `valid`. A demultiplexer can spread successive windows across several parallel engines.

The window moves right by `HS` pixels and down by `VS` lines, with `1 <= HS <= H` and `1 <= VS <= V`. The block processes `PLINES = V + floor((FRAME_LEN-V)/VS)*VS` lines per frame and ignores any lines below them. It processes `PCOLS = H + floor((FRAME_WID-H)/HS)*HS` pixels per line and discards the pixels to the right of them in a skip state. No window that crosses a frame edge is ever produced.

Internally the block has four parts:
- A write controller with the states `WR_IDLE`, `WR_FRAME`, `WR_LINE`, `WR_STORE` and `WR_SKIP`.
- The line store. Its read-side rotator puts the circular buffer rows back into top-to-bottom order.
- A horizontal column shift register.
- A read controller with the states `RD_IDLE`, `RD_FIRST`, `RD_EMIT` and `RD_NEXT`.

Write controller transitions:
- `WR_IDLE` goes to `WR_FRAME` when `vblank` is high.
- `WR_FRAME` goes to `WR_LINE` when `hblank` is high and `vblank` is low.
- `WR_LINE` goes to `WR_STORE` on an active pixel, or to `WR_SKIP` if `PCOLS` is 1. It goes back to `WR_FRAME` on `vblank`.
- `WR_STORE` goes to `WR_SKIP` after storing column `PCOLS-1`.
- `WR_STORE` and `WR_SKIP` both leave when `act_video` falls. They go to `WR_LINE`, or to `WR_FRAME` if `vblank` is high.

Read controller transitions:
- `RD_IDLE` goes to `RD_FIRST` at a frame start.
- `RD_FIRST` goes to `RD_EMIT` on the first window, which carries `sof`.
- `RD_EMIT` goes to `RD_NEXT` at the end of a window row line, or to `RD_IDLE` after line `PLINES-1`.
- `RD_NEXT` goes back to `RD_EMIT` on the first window of the next window row.
- A frame start moves the read controller from any state to `RD_FIRST`.

Top module: `mb_distrib`

## Requirements
- R1: Window element (row k, column j) sits at `blk[(k*H+j)*PW +: PW]`. It equals the frame pixel at line `top+k`, column `left+j`. Row 0 is the top line, whichever circular buffer holds it.
- R2: A window whose right column is frame column c appears with `valid` exactly one clock after the pixel of column c on its bottom line was accepted.
- R3: Windows appear only at columns c with c >= H-1 and (c-(H-1)) a multiple of HS. With HS > 1, `valid` is never high on two consecutive clocks.
- R4: Windows appear only on bottom lines r with r >= V-1, (r-(V-1)) a multiple of VS, and r < PLINES.
- R5: `sof` is high together with the first window of each frame and at no other time. `sof` implies `valid`.
- R6: Pixels at columns PCOLS and above never form part of any window.
- R7: Lines at PLINES and below in the frame produce no window. Each frame yields exactly ((PCOLS-H)/HS+1)*((PLINES-V)/VS+1) windows.
- R8: A synchronous active-high `rst` returns both controllers to idle. On the following clock `valid` and `sof` are low.
- R9: Only pixels with `act_video` high are accepted. Each `valid` follows a clock on which `act_video` was high.
- R10: A new `vblank` restarts line counting and buffer indexing, so a second frame yields the same sequence of window positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vblank | input | 1 | Vertical blanking, high before a frame |
| hblank | input | 1 | Horizontal blanking, high before each line |
| act_video | input | 1 | Pixel qualifier |
| din | input | PW | Pixel value |
| blk | output | H*V*PW | Window, element (k,j) at bit (k*H+j)*PW |
| valid | output | 1 | Window present on `blk` |
| sof | output | 1 | First window of the frame |

## Verification
The bench streams two frames whose width and length leave one trailing column and one trailing line unprocessed, with a slide of 2 in both directions. Every window is compared element by element against pixel values computed arithmetically from line, column and frame.

The comparison catches these faults:
- A rotator that skips re-ordering would give rows shuffled once the buffer index wraps.
- A wrong stride would give windows at wrong positions.
- A missing skip would let the trailing column or bottom line produce extra windows, which shows up in the per-frame count.
- A misplaced `sof` or a stale frame restart would break the second frame's sequence.

// File: rtl/mb_distrib_pkg.sv
package mb_distrib_pkg;
    typedef enum logic [2:0] {
        WR_IDLE, WR_FRAME, WR_LINE, WR_STORE, WR_SKIP
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE, RD_FIRST, RD_EMIT, RD_NEXT
    } rd_state_t;
endpackage

// File: rtl/mb_wr_ctrl.sv
module mb_wr_ctrl
    import mb_distrib_pkg::*;
#(
    parameter int FRAME_WID = 12,
    parameter int FRAME_LEN = 10,
    parameter int V         = 3,
    parameter int PCOLS     = 11,
    parameter int PLINES    = 9,
    parameter int CW        = 4,
    parameter int RW        = 4,
    parameter int BW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vblank,
    input  logic          hblank,
    input  logic          act_video,
    output logic          store_en,
    output logic          frame_start,
    output logic          line_end,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic [BW-1:0] wbuf,
    output logic [BW-1:0] top
);
    wr_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= WR_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:  if (vblank) nxt = WR_FRAME;
            WR_FRAME: if (hblank && !vblank) nxt = WR_LINE;
            WR_LINE: begin
                if (vblank)         nxt = WR_FRAME;
                else if (act_video) nxt = (PCOLS == 1) ? WR_SKIP : WR_STORE;
            end
            WR_STORE: begin
                if (!act_video)                   nxt = vblank ? WR_FRAME : WR_LINE;
                else if (int'(col) == PCOLS - 1)  nxt = WR_SKIP;
            end
            WR_SKIP:  if (!act_video) nxt = vblank ? WR_FRAME : WR_LINE;
            default:  nxt = WR_IDLE;
        endcase
    end

    always_comb begin
        store_en    = act_video && (state == WR_LINE || state == WR_STORE)
                      && (int'(row) < PLINES);
        frame_start = (nxt == WR_FRAME) && (state != WR_FRAME);
        line_end    = (state == WR_STORE || state == WR_SKIP) && !act_video;
        top         = (int'(wbuf) == V - 1) ? '0 : wbuf + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= '0;
            row  <= '0;
            wbuf <= '0;
        end else begin
            if (!act_video || state == WR_IDLE)   col <= '0;
            else if (int'(col) < FRAME_WID - 1)   col <= col + 1'b1;
            if (frame_start) begin
                row  <= '0;
                wbuf <= '0;
            end else if (line_end) begin
                if (int'(row) < FRAME_LEN) row <= row + 1'b1;
                wbuf <= (int'(wbuf) == V - 1) ? '0 : wbuf + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mb_line_store.sv
module mb_line_store #(
    parameter int PW        = 8,
    parameter int FRAME_WID = 12,
    parameter int V         = 3,
    parameter int CW        = 4,
    parameter int BW        = 2
) (
    input  logic            clk,
    input  logic            store_en,
    input  logic [CW-1:0]   col,
    input  logic [BW-1:0]   wbuf,
    input  logic [BW-1:0]   top,
    input  logic [PW-1:0]   din,
    output logic [V*PW-1:0] column
);
    logic [PW-1:0] mem [V][FRAME_WID];

    for (genvar b = 0; b < V; b++) begin : g_buf
        always_ff @(posedge clk) begin
            if (store_en && int'(wbuf) == b) mem[b][col] <= din;
        end
    end

    // Rotator: row k of the window reads buffer (top + k) mod V;
    // the bottom row is the pixel being written this cycle.
    always_comb begin
        for (int k = 0; k < V; k++) begin
            int idx;
            idx = int'(top) + k;
            if (idx >= V) idx = idx - V;
            if (k == V - 1) column[k*PW +: PW] = din;
            else            column[k*PW +: PW] = mem[idx][col];
        end
    end
endmodule

// File: rtl/mb_hshift.sv
module mb_hshift #(
    parameter int PW = 8,
    parameter int H  = 3,
    parameter int V  = 3
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic [V*PW-1:0]   column,
    output logic [H*V*PW-1:0] blk
);
    logic [V*PW-1:0] sr [H];

    always_ff @(posedge clk) begin
        if (shift_en) begin
            sr[H-1] <= column;
            for (int j = 0; j < H - 1; j++) sr[j] <= sr[j+1];
        end
    end

    for (genvar k = 0; k < V; k++) begin : g_row
        for (genvar j = 0; j < H; j++) begin : g_col
            assign blk[(k*H+j)*PW +: PW] = sr[j][k*PW +: PW];
        end
    end
endmodule

// File: rtl/mb_rd_ctrl.sv
module mb_rd_ctrl
    import mb_distrib_pkg::*;
#(
    parameter int H      = 3,
    parameter int V      = 3,
    parameter int HS     = 2,
    parameter int VS     = 2,
    parameter int PLINES = 9,
    parameter int CW     = 4,
    parameter int RW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          store_en,
    input  logic          frame_start,
    input  logic          line_end,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    output logic          valid,
    output logic          sof
);
    rd_state_t state, nxt;
    logic      emit;

    always_comb begin
        emit = store_en
            && int'(col) >= H - 1 && ((int'(col) - (H - 1)) % HS) == 0
            && int'(row) >= V - 1 && ((int'(row) - (V - 1)) % VS) == 0
            && int'(row) < PLINES;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RD_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  ;
            RD_FIRST: if (emit) nxt = RD_EMIT;
            RD_EMIT:  if (line_end) nxt = (int'(row) >= PLINES - 1) ? RD_IDLE : RD_NEXT;
            RD_NEXT:  if (emit) nxt = RD_EMIT;
            default:  nxt = RD_IDLE;
        endcase
        if (frame_start) nxt = RD_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            sof   <= 1'b0;
        end else begin
            valid <= emit && state != RD_IDLE;
            sof   <= emit && state == RD_FIRST;
        end
    end
endmodule

// File: rtl/mb_distrib.sv
module mb_distrib
    import mb_distrib_pkg::*;
#(
    parameter int PW        = 8,
    parameter int FRAME_WID = 12,
    parameter int FRAME_LEN = 10,
    parameter int H         = 3,
    parameter int V         = 3,
    parameter int HS        = 2,
    parameter int VS        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              act_video,
    input  logic [PW-1:0]     din,
    output logic [H*V*PW-1:0] blk,
    output logic              valid,
    output logic              sof
);
    localparam int PCOLS  = H + ((FRAME_WID - H) / HS) * HS;
    localparam int PLINES = V + ((FRAME_LEN - V) / VS) * VS;
    localparam int CW     = (FRAME_WID > 1) ? $clog2(FRAME_WID) : 1;
    localparam int RW     = $clog2(FRAME_LEN + 1);
    localparam int BW     = (V > 1) ? $clog2(V) : 1;

    logic            store_en, frame_start, line_end;
    logic [CW-1:0]   col;
    logic [RW-1:0]   row;
    logic [BW-1:0]   wbuf, top;
    logic [V*PW-1:0] column;

    mb_wr_ctrl #(
        .FRAME_WID(FRAME_WID), .FRAME_LEN(FRAME_LEN), .V(V),
        .PCOLS(PCOLS), .PLINES(PLINES), .CW(CW), .RW(RW), .BW(BW)
    ) u_wr (
        .clk(clk), .rst(rst), .vblank(vblank), .hblank(hblank),
        .act_video(act_video), .store_en(store_en),
        .frame_start(frame_start), .line_end(line_end),
        .col(col), .row(row), .wbuf(wbuf), .top(top)
    );

    mb_line_store #(
        .PW(PW), .FRAME_WID(FRAME_WID), .V(V), .CW(CW), .BW(BW)
    ) u_store (
        .clk(clk), .store_en(store_en), .col(col), .wbuf(wbuf),
        .top(top), .din(din), .column(column)
    );

    mb_hshift #(.PW(PW), .H(H), .V(V)) u_hsr (
        .clk(clk), .shift_en(store_en), .column(column), .blk(blk)
    );

    mb_rd_ctrl #(
        .H(H), .V(V), .HS(HS), .VS(VS), .PLINES(PLINES), .CW(CW), .RW(RW)
    ) u_rd (
        .clk(clk), .rst(rst), .store_en(store_en),
        .frame_start(frame_start), .line_end(line_end),
        .col(col), .row(row), .valid(valid), .sof(sof)
    );
endmodule

// File: rtl/mb_distrib_chk.sv
module mb_distrib_chk #(
    parameter int HS = 2
) (
    input logic clk,
    input logic rst,
    input logic act_video,
    input logic valid,
    input logic sof
);
    // R3: with a horizontal slide above one, windows never come back to back
    a_r3_stride_gap: assert property (@(posedge clk) disable iff (rst)
        ((HS > 1) && valid) |=> !valid);

    // R5: sof only travels with a window
    a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
        sof |-> valid);

    // R5: sof is a single-window pulse
    a_r5_sof_single: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    // R8: reset clears both strobes on the next clock
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid && !sof));

    // R9: each window follows an accepted pixel
    a_r9_valid_after_pixel: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(act_video));
endmodule

bind mb_distrib mb_distrib_chk #(.HS(HS)) u_chk (
    .clk(clk), .rst(rst), .act_video(act_video), .valid(valid), .sof(sof)
);

// File: tb/mb_distrib_bench.sv
module mb_distrib_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8, FW = 12, FL = 10, H = 3, V = 3, HS = 2, VS = 2;
    localparam int PCOLS  = H + ((FW - H) / HS) * HS;
    localparam int PLINES = V + ((FL - V) / VS) * VS;
    localparam int NBLK   = ((PCOLS - H) / HS + 1) * ((PLINES - V) / VS + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic vblank = 1'b0, hblank = 1'b0, act_video = 1'b0;
    logic [PW-1:0] din = '0;
    logic [H*V*PW-1:0] blk;
    logic valid, sof;

    int checks = 0, fails = 0, cycles = 0;
    int frame_no = 0, exp_r = V - 1, exp_c = H - 1, blk_cnt = 0;
    bit done = 0;

    mb_distrib #(.PW(PW), .FRAME_WID(FW), .FRAME_LEN(FL), .H(H), .V(V),
                 .HS(HS), .VS(VS)) u_mb_distrib (
        .clk(clk), .rst(rst), .vblank(vblank), .hblank(hblank),
        .act_video(act_video), .din(din), .blk(blk), .valid(valid), .sof(sof));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PW-1:0] pix(int f, int r, int c);
        return PW'((r * 16 + c + f * 37) & 8'hff);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_frame(int f);
        frame_no = f; exp_r = V - 1; exp_c = H - 1; blk_cnt = 0;
        vblank = 1'b1; din = 8'hAA;
        repeat (3) tick();
        vblank = 1'b0;
        for (int r = 0; r < FL; r++) begin
            hblank = 1'b1; din = 8'h55;
            repeat (2) tick();
            hblank = 1'b0;
            for (int c = 0; c < FW; c++) begin
                act_video = 1'b1; din = pix(f, r, c);
                tick();
            end
            act_video = 1'b0; din = 8'hEE;
        end
        repeat (4) tick();
    endtask

    // Monitor: windows sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && !done && valid) begin
            bit ok = 1;
            int bad_a = 0, bad_e = 0;
            for (int k = 0; k < V; k++)
                for (int j = 0; j < H; j++) begin
                    logic [PW-1:0] e;
                    e = pix(frame_no, exp_r - (V - 1) + k, exp_c - (H - 1) + j);
                    if (blk[(k*H+j)*PW +: PW] !== e) begin
                        ok = 0; bad_a = int'(blk[(k*H+j)*PW +: PW]); bad_e = int'(e);
                    end
                end
            // R1 R2 R3 R4: contents and position of each window
            check(ok, "R1/R2 window contents", bad_a, bad_e);
            check(exp_r < PLINES, "R4 window row in range", exp_r, PLINES - 1);
            // R5: sof only on the first window
            check(sof == (blk_cnt == 0), "R5 sof placement", int'(sof), int'(blk_cnt == 0));
            blk_cnt++;
            exp_c += HS;
            if (exp_c > PCOLS - 1) begin exp_c = H - 1; exp_r += VS; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0; tick();
        // R8: reset leaves the strobes low
        check(valid == 1'b0 && sof == 1'b0, "R8 reset strobes", int'(valid), 0);
        // R9: blanking and junk without act_video give nothing
        hblank = 1'b1; din = 8'h12; repeat (5) tick(); hblank = 1'b0;
        check(blk_cnt == 0, "R9 no window without pixels", blk_cnt, 0);
        send_frame(0);
        // R6 R7: trailing column and bottom line add no windows
        check(blk_cnt == NBLK, "R6/R7 window count frame 0", blk_cnt, NBLK);
        check(exp_r == PLINES - 1 + VS, "R7 last window row frame 0", exp_r, PLINES - 1 + VS);
        send_frame(1);
        // R10: restart on vblank
        check(blk_cnt == NBLK, "R10 window count frame 1", blk_cnt, NBLK);
        // R8: reset mid-stream
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check(valid == 1'b0 && sof == 1'b0, "R8 reset mid-stream", int'(valid), 0);
        send_frame(2);
        check(blk_cnt == NBLK, "R10 window count after reset", blk_cnt, NBLK);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule